// File: doc/BRIEF.md
# Reconfigurable Word Operator

A pipelined word-level operator cell for a coarse-grain reconfigurable datapath. A controller writes an opcode into a configuration register. Every operand pair accepted afterwards is processed under that opcode. The cell takes two operands and returns one result a fixed four cycles after the operands are accepted.

The function set covers several groups:
- wrapping arithmetic, bitwise logic, logical shifts and absolute value;
- a 16x16 unsigned multiply, which can also run as two independent 8x8 multiplies;
- two accumulating functions, sum of absolute differences and multiply-accumulate, which add into an internal accumulator of the full data width.

A clear input, sampled together with an operand, starts a new sum. The data width is a parameter, 32 or 40 bits.

The opcode travels down the pipeline with its operands. A configuration change therefore never alters work already in flight, and the cell can be reprogrammed between any two operands without draining.

Top module: `rcfg_operator`

## Requirements
- R1: An operand pair accepted with `in_valid_i` high at a rising edge appears on `res_o` with `res_valid_o` high exactly four rising edges after that edge. `res_valid_o` is never high for a cycle in which no operand was accepted four edges earlier.
- R2: After reset the following hold: `res_valid_o` is 0, `res_o` is 0, the configuration is ADD, and the accumulator is 0.
- R3: Opcode 0 (ADD) gives a+b and opcode 1 (SUB) gives a-b, both wrapping modulo 2^DATA_W.
- R4: Opcode 5 gives a AND b, opcode 6 gives a OR b, and opcode 7 gives a XOR b.
- R5: Opcode 8 shifts a left and opcode 9 shifts a right logically, by the amount in b[5:0]. Any amount of DATA_W or more gives 0.
- R6: Opcode 4 (ABS) gives the two's-complement magnitude of a. The most negative value is returned unchanged.
- R7: Opcode 2 gives the unsigned product a[15:0]*b[15:0], zero-extended. Higher operand bits are ignored.
- R8: Opcode 3 (split multiply) places a[7:0]*b[7:0] in result bits [15:0] and a[15:8]*b[15:8] in bits [31:16]. All bits above 31 are zero.
- R9: Opcode 10 (SAD) adds |a-b|, with a and b read as signed DATA_W values, to the accumulator. The sum wraps modulo 2^DATA_W and the new sum is the result.
- R10: Opcode 11 (MAC) adds the unsigned product a[15:0]*b[15:0] to the accumulator, wrapping, and the new sum is the result.
- R11: When `acc_clr_i` is high with an accepted SAD or MAC operand, that operand's term alone becomes the new sum. `acc_clr_i` without `in_valid_i` has no effect. Non-accumulating operations leave the accumulator unchanged.
- R12: `cfg_we_i` loads `cfg_op_i` into the configuration at the edge. An operand accepted at that same edge, and every operand already in flight, uses the previous configuration.
- R13: Opcodes 12 to 15 produce a result of 0 and leave the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_op_i | input | 4 | Opcode to load |
| in_valid_i | input | 1 | Operand pair valid |
| a_i | input | DATA_W | First operand |
| b_i | input | DATA_W | Second operand |
| acc_clr_i | input | 1 | Start a new accumulation with this operand |
| res_valid_o | output | 1 | Result valid |
| res_o | output | DATA_W | Result |

## Verification
Every result is due four rising edges after its operand is accepted. No result arrives earlier or later, whatever the opcode, and accumulating results are chained through the accumulator in issue order. The bench drives operands on the falling edge and files each expected value in a slot four cycles ahead. At every falling edge it compares both `res_valid_o` and `res_o` with that cycle's slot, so a missing, early or late result fails. The expected values come from a reference model that holds its own copy of the configuration and the accumulator. The model applies a configuration write only after computing the result of an operand issued in the same cycle.

// File: rtl/rop_pkg.sv
package rop_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_MUL  = 4'd2,
    OP_MUL2 = 4'd3,
    OP_ABS  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_SHL  = 4'd8,
    OP_SHR  = 4'd9,
    OP_SAD  = 4'd10,
    OP_MAC  = 4'd11
  } op_e;

  localparam int unsigned OP_W  = 4;
  localparam int unsigned SH_W  = 6;
  localparam int unsigned MUL_W = 16;
  localparam int unsigned PRD_W = 2 * MUL_W;

  function automatic logic is_acc(input logic [OP_W-1:0] op);
    return (op == OP_SAD) || (op == OP_MAC);
  endfunction
endpackage

// File: rtl/rop_alu.sv
module rop_alu
  import rop_pkg::*;
#(
  parameter int unsigned DATA_W = 40
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o,
  output logic [DATA_W-1:0] absd_o
);
  logic [SH_W-1:0] sh;
  logic [DATA_W:0] diff;

  assign sh = b_i[SH_W-1:0];

  always_comb begin
    unique case (op_i)
      OP_ADD:  res_o = a_i + b_i;
      OP_SUB:  res_o = a_i - b_i;
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_SHL:  res_o = (sh >= SH_W'(DATA_W)) ? '0 : (a_i << sh);
      OP_SHR:  res_o = (sh >= SH_W'(DATA_W)) ? '0 : (a_i >> sh);
      OP_ABS:  res_o = a_i[DATA_W-1] ? (~a_i + 1'b1) : a_i;
      default: res_o = '0;
    endcase
  end

  // signed difference one bit wider, so its magnitude cannot overflow
  assign diff = {a_i[DATA_W-1], a_i} - {b_i[DATA_W-1], b_i};

  always_comb begin
    logic [DATA_W:0] mag;
    mag    = diff[DATA_W] ? (~diff + 1'b1) : diff;
    absd_o = mag[DATA_W-1:0];
  end
endmodule

// File: rtl/rop_mul.sv
module rop_mul
  import rop_pkg::*;
(
  input  logic [MUL_W-1:0] a_i,
  input  logic [MUL_W-1:0] b_i,
  output logic [PRD_W-1:0] wide_o,
  output logic [PRD_W-1:0] split_o
);
  localparam int unsigned LANE_W = MUL_W / 2;
  localparam int unsigned LANES  = 2;

  logic [MUL_W-1:0] pp [LANES*LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_ai
    for (genvar j = 0; j < LANES; j++) begin : g_bj
      assign pp[i*LANES+j] = a_i[i*LANE_W +: LANE_W] * b_i[j*LANE_W +: LANE_W];
    end
  end

  // the two diagonal partial products are the split lanes
  assign split_o = {pp[3], pp[0]};
  assign wide_o  = PRD_W'(pp[0])
                 + (PRD_W'(pp[1]) << LANE_W)
                 + (PRD_W'(pp[2]) << LANE_W)
                 + (PRD_W'(pp[3]) << MUL_W);
endmodule

// File: rtl/rop_accum.sv
module rop_accum #(
  parameter int unsigned DATA_W = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] term_i,
  output logic [DATA_W-1:0] acc_o
);
  logic [DATA_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (en_i)  acc_q <= clr_i ? term_i : acc_q + term_i;
  end

  assign acc_o = acc_q;

  // R11: accumulator moves only for an accepted SAD or MAC operand
  a_r11_acc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(acc_q));
endmodule

// File: rtl/rcfg_operator.sv
module rcfg_operator
  import rop_pkg::*;
#(
  parameter int unsigned DATA_W = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [3:0]        cfg_op_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              acc_clr_i,
  output logic              res_valid_o,
  output logic [DATA_W-1:0] res_o
);
  // configuration
  logic [OP_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= OP_ADD;
    else if (cfg_we_i) cfg_q <= cfg_op_i;
  end

  // stage 1: capture operands with the opcode in force before any write this edge
  logic              s1_v, s1_clr;
  logic [OP_W-1:0]   s1_op;
  logic [DATA_W-1:0] s1_a, s1_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v <= 1'b0; s1_clr <= 1'b0; s1_op <= OP_ADD; s1_a <= '0; s1_b <= '0;
    end else begin
      s1_v <= in_valid_i;
      if (in_valid_i) begin
        s1_clr <= acc_clr_i;
        s1_op  <= cfg_q;
        s1_a   <= a_i;
        s1_b   <= b_i;
      end
    end
  end

  // stage 2: compute
  logic [DATA_W-1:0] alu_d, absd_d;
  logic [PRD_W-1:0]  wide_d, split_d;

  rop_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i  (s1_op),
    .a_i   (s1_a),
    .b_i   (s1_b),
    .res_o (alu_d),
    .absd_o(absd_d)
  );

  rop_mul u_mul (
    .a_i    (s1_a[MUL_W-1:0]),
    .b_i    (s1_b[MUL_W-1:0]),
    .wide_o (wide_d),
    .split_o(split_d)
  );

  logic              s2_v, s2_clr;
  logic [OP_W-1:0]   s2_op;
  logic [DATA_W-1:0] s2_alu, s2_absd;
  logic [PRD_W-1:0]  s2_wide, s2_split;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_v <= 1'b0; s2_clr <= 1'b0; s2_op <= OP_ADD;
      s2_alu <= '0; s2_absd <= '0; s2_wide <= '0; s2_split <= '0;
    end else begin
      s2_v <= s1_v;
      if (s1_v) begin
        s2_clr   <= s1_clr;
        s2_op    <= s1_op;
        s2_alu   <= alu_d;
        s2_absd  <= absd_d;
        s2_wide  <= wide_d;
        s2_split <= split_d;
      end
    end
  end

  // stage 3: select or accumulate
  logic              acc_en;
  logic [DATA_W-1:0] acc_term, acc_val, sel_d;

  assign acc_en   = s2_v && is_acc(s2_op);
  assign acc_term = (s2_op == OP_SAD) ? s2_absd : DATA_W'(s2_wide);

  rop_accum #(.DATA_W(DATA_W)) u_acc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (acc_en),
    .clr_i (s2_clr),
    .term_i(acc_term),
    .acc_o (acc_val)
  );

  always_comb begin
    unique case (s2_op)
      OP_MUL:  sel_d = DATA_W'(s2_wide);
      OP_MUL2: sel_d = DATA_W'(s2_split);
      default: sel_d = s2_alu;
    endcase
  end

  logic              s3_v, s3_acc;
  logic [OP_W-1:0]   s3_op;
  logic [DATA_W-1:0] s3_res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s3_v <= 1'b0; s3_acc <= 1'b0; s3_op <= OP_ADD; s3_res <= '0;
    end else begin
      s3_v <= s2_v;
      if (s2_v) begin
        s3_acc <= is_acc(s2_op);
        s3_op  <= s2_op;
        s3_res <= sel_d;
      end
    end
  end

  // stage 4: output register
  logic [OP_W-1:0] s4_op;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0; res_o <= '0; s4_op <= OP_ADD;
    end else begin
      res_valid_o <= s3_v;
      if (s3_v) begin
        res_o <= s3_acc ? acc_val : s3_res;
        s4_op <= s3_op;
      end
    end
  end

  // R1: fixed four-edge latency in both directions
  a_r1_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> ##4 res_valid_o);
  a_r1_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |-> ##4 !res_valid_o);

  // R8: split products never reach above bit 31
  a_r8_split_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && s4_op == OP_MUL2) |-> (res_o >> PRD_W) == '0);

  // R12: configuration holds without a write strobe
  a_r12_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(cfg_q));
endmodule

// File: tb/rcfg_operator_test.sv
module rcfg_operator_test;
  localparam int DW       = 40;
  localparam int CLK_PER  = 10;
  localparam int WATCHDOG = 100000;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [3:0]    cfg_op_i = '0;
  logic          in_valid_i = 1'b0;
  logic [DW-1:0] a_i = '0, b_i = '0;
  logic          acc_clr_i = 1'b0;
  logic          res_valid_o;
  logic [DW-1:0] res_o;

  rcfg_operator #(.DATA_W(DW)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_op_i(cfg_op_i),
    .in_valid_i(in_valid_i), .a_i(a_i), .b_i(b_i), .acc_clr_i(acc_clr_i),
    .res_valid_o(res_valid_o), .res_o(res_o)
  );

  always #(CLK_PER/2) clk_i = ~clk_i;

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  logic          exp_v [8];
  logic [DW-1:0] exp_d [8];
  string         exp_t [8];
  logic [3:0]    m_cfg = 4'd0;
  logic [DW-1:0] m_acc = '0;

  function automatic string op_tag(input logic [3:0] op);
    case (op)
      4'd0, 4'd1:       return "R3";
      4'd5, 4'd6, 4'd7: return "R4";
      4'd8, 4'd9:       return "R5";
      4'd4:             return "R6";
      4'd2:             return "R7";
      4'd3:             return "R8";
      4'd10:            return "R9";
      4'd11:            return "R10";
      default:          return "R13";
    endcase
  endfunction

  function automatic logic [DW-1:0] prod16(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return DW'(32'(a[15:0]) * 32'(b[15:0]));
  endfunction

  function automatic logic [DW-1:0] sad_term(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic signed [DW:0] d;
    d = $signed({a[DW-1], a}) - $signed({b[DW-1], b});
    if (d < 0) d = -d;
    return d[DW-1:0];
  endfunction

  // reference model; updates the model accumulator
  function logic [DW-1:0] model(input logic [3:0] op, input logic [DW-1:0] a,
                                input logic [DW-1:0] b, input logic clr);
    int sh;
    sh = int'(b[5:0]);
    case (op)
      4'd0:  return a + b;
      4'd1:  return a - b;
      4'd2:  return prod16(a, b);
      4'd3:  return DW'({16'(a[15:8] * b[15:8]), 16'(a[7:0] * b[7:0])});
      4'd4:  return a[DW-1] ? -a : a;
      4'd5:  return a & b;
      4'd6:  return a | b;
      4'd7:  return a ^ b;
      4'd8:  return (sh >= DW) ? '0 : a << sh;
      4'd9:  return (sh >= DW) ? '0 : a >> sh;
      4'd10: begin m_acc = (clr ? '0 : m_acc) + sad_term(a, b); return m_acc; end
      4'd11: begin m_acc = (clr ? '0 : m_acc) + prod16(a, b); return m_acc; end
      default: return '0;
    endcase
  endfunction

  task automatic check_slot();
    int i;
    i = cyc % 8;
    n_checks++;
    if (res_valid_o !== exp_v[i] || (exp_v[i] && res_o !== exp_d[i])) begin
      n_errors++;
      $display("FAIL %s: valid=%0b res=%h expected valid=%0b res=%h",
               exp_v[i] ? exp_t[i] : "R1", res_valid_o, res_o, exp_v[i], exp_d[i]);
    end
  endtask

  task automatic step(input logic we, input logic [3:0] wop, input logic v,
                      input logic [DW-1:0] a, input logic [DW-1:0] b,
                      input logic clr, input string tag);
    int s;
    @(negedge clk_i);
    check_slot();
    cfg_we_i = we; cfg_op_i = wop; in_valid_i = v; a_i = a; b_i = b; acc_clr_i = clr;
    s = (cyc + 4) % 8;
    exp_v[s] = v;
    if (v) begin
      exp_d[s] = model(m_cfg, a, b, clr);
      exp_t[s] = (tag == "") ? op_tag(m_cfg) : tag;
    end
    if (we) m_cfg = wop;
  endtask

  task automatic setop(input logic [3:0] op);
    step(1'b1, op, 1'b0, '0, '0, 1'b0, "");
  endtask

  task automatic go(input logic [DW-1:0] a, input logic [DW-1:0] b, input logic clr);
    step(1'b0, 4'd0, 1'b1, a, b, clr, "");
  endtask

  function automatic logic [DW-1:0] rnd();
    return {8'($urandom), $urandom};
  endfunction

  initial begin
    #(CLK_PER * WATCHDOG);
    n_errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin exp_v[i] = 1'b0; exp_d[i] = '0; exp_t[i] = "R1"; end
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    n_checks++;
    if (res_valid_o !== 1'b0 || res_o !== '0) begin
      n_errors++;
      $display("FAIL R2: valid=%0b res=%h expected valid=0 res=0", res_valid_o, res_o);
    end
    rst_ni = 1'b1;

    // R2: default ADD, accumulator starts at zero
    step(1'b0, 4'd0, 1'b1, 40'd5, 40'd7, 1'b0, "R2");
    setop(4'd10);
    step(1'b0, 4'd0, 1'b1, 40'd10, 40'd3, 1'b0, "R2");
    // R3 wrap
    setop(4'd0); go('1, 40'd1, 1'b0);
    setop(4'd1); go('0, 40'd1, 1'b0);
    // R4
    setop(4'd5); go(40'hF0F0_F0F0_F0, 40'hFF00_FF00_FF, 1'b0);
    setop(4'd6); go(40'hF0F0_F0F0_F0, 40'h0F00_0F00_0F, 1'b0);
    setop(4'd7); go(40'hAAAA_AAAA_AA, 40'hFFFF_0000_FF, 1'b0);
    // R5 shift amounts, including >= width
    setop(4'd8); go(40'h1, 40'd4, 1'b0); go(40'h3, 40'd40, 1'b0); go(40'h3, 40'd39, 1'b0);
    setop(4'd9); go('1, 40'd39, 1'b0); go('1, 40'd63, 1'b0);
    // R6
    setop(4'd4); go(-40'sd5, '0, 1'b0); go({1'b1, 39'd0}, '0, 1'b0);
    // R7 upper operand bits ignored
    setop(4'd2); go(40'hAB_0000_FFFF, 40'hCD_0000_FFFF, 1'b0);
    // R8 split lanes
    setop(4'd3); go(40'h12FF, 40'h34FF, 1'b0); go('1, '1, 1'b0);
    // R9 SAD with wrap
    setop(4'd10); go(40'h7F_FFFF_FFFF, {1'b1, 39'd0}, 1'b1); go(40'd2, -40'sd3, 1'b0);
    // R10 MAC chain, back to back
    setop(4'd11); go(40'hFFFF, 40'hFFFF, 1'b1); go(40'd3, 40'd4, 1'b0); go(40'd5, 40'd6, 1'b0);
    // R11 clear without valid ignored; non-accumulating op leaves sum
    step(1'b0, 4'd0, 1'b0, '0, '0, 1'b1, "R11");
    go(40'd1, 40'd1, 1'b0);
    setop(4'd0); go(40'd9, 40'd9, 1'b1);
    setop(4'd11);
    step(1'b0, 4'd0, 1'b1, 40'd2, 40'd2, 1'b0, "R11");
    step(1'b0, 4'd0, 1'b1, 40'd7, 40'd1, 1'b1, "R11");
    // R12 write at the same edge as an operand; in-flight work unaffected
    setop(4'd0);
    step(1'b1, 4'd1, 1'b1, 40'd20, 40'd4, 1'b0, "R12");
    step(1'b1, 4'd7, 1'b1, 40'd20, 40'd4, 1'b0, "R12");
    step(1'b0, 4'd0, 1'b1, 40'd20, 40'd4, 1'b0, "R12");
    // R13
    setop(4'd15); go(40'd123, 40'd456, 1'b0);
    setop(4'd12); go('1, '1, 1'b1);
    setop(4'd11); go(40'd1, 40'd1, 1'b0);

    // R1: random mix of valids, writes and clears
    for (int k = 0; k < 3000; k++) begin
      logic [DW-1:0] ra, rb;
      ra = rnd();
      rb = ($urandom % 4 == 0) ? DW'($urandom % 64) : rnd();
      step(($urandom % 5) == 0, 4'($urandom), ($urandom % 4) != 0, ra, rb,
           ($urandom % 8) == 0, "");
    end
    repeat (8) step(1'b0, 4'd0, 1'b0, '0, '0, 1'b0, "R1");

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule